// File: doc/BRIEF.md
# Socket Receive Buffer Drainer

This block empties one pass of received data for a single network socket out of an external network controller. The controller keeps each socket's received bytes in a circular region of its own packet memory. A one-cycle start pulse selects a socket. The block then runs a fixed series of register reads, burst data reads and register writes through an abstract access port, and streams the bytes it gets into an on-chip FIFO.

The block first asks how many bytes are waiting. It then picks a pass length that is the smallest of three values: that count, a maximum segment size and the free space in the destination FIFO. It fetches the 16-bit read pointer and reduces it to an offset inside the 2 KB region. When the pass runs past the end of the region, it splits the transfer into two bursts. Afterwards it writes back the advanced pointer, issues the receive-done command and polls the command register until the controller clears it. A done pulse then reports the byte count of the pass. Bytes beyond the length chosen are left in the controller for a later pass.

Top module: `rx_drain`

## Requirements
- R1: When the size register (register select 0) reads zero, the pass makes no further access and ends with a done pulse and a count of 0.
- R2: A non-empty pass makes its accesses in this order: size read, read-pointer read (register select 1), one or two burst reads, read-pointer write, command write (register select 2), then command reads. Operation codes are 0 for register read, 1 for register write and 2 for burst read. A request and its fields stay stable until acknowledged.
- R3: The first burst starts at the read pointer modulo 2048, which is its low 11 bits.
- R4: When the pass crosses offset 2048, the first burst covers the bytes up to the region end and a second burst from offset 0 covers the rest. A pass that ends exactly at the region end uses one burst.
- R5: The pass length is the minimum of the received size, 1460 and the FIFO free count, so no pass exceeds 1460 bytes.
- R6: With a FIFO free count of zero, the pass ends after the size read with a count of 0 and makes no pointer access.
- R7: The value written to the read pointer is the old pointer plus the pass length, modulo 65536.
- R8: The command write carries the value 0x0040. Done is not raised until a command-register read returns zero, and the block keeps reading while it does not.
- R9: Done is a one-cycle pulse with the pass length on the count output. The FIFO receives exactly that many bytes, in burst order, one cycle after each accepted data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a pass while idle |
| sock_sel | input | 3 | Socket to drain |
| fifo_free | input | 12 | Free byte count of the destination FIFO |
| acc_req | output | 1 | Access request, held until acknowledged |
| acc_op | output | 2 | 0 register read, 1 register write, 2 burst read |
| acc_reg | output | 2 | 0 received size, 1 read pointer, 2 command |
| acc_sock | output | 3 | Socket addressed by the access |
| acc_addr | output | 11 | Burst start offset inside the region |
| acc_len | output | 11 | Burst byte count |
| acc_wdata | output | 16 | Register write value |
| acc_ack | input | 1 | Access accepted; read data valid with it |
| acc_rdata | input | 16 | Register read value |
| dat_valid | input | 1 | Burst data beat valid |
| dat_byte | input | 8 | Burst data byte |
| fifo_push | output | 1 | Write strobe into the FIFO |
| fifo_data | output | 8 | Byte written into the FIFO |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| done_len | output | 11 | Bytes moved in the pass, valid with done |

## Verification
Each access is accepted on the clock edge where request and acknowledge are both high. The next request or burst wait begins in the following cycle. Every data beat reaches the FIFO one cycle after the edge that accepts it. Done rises in the cycle after the zero-valued command read is accepted, or after the size read on an empty or blocked pass, and it drops one cycle later. The bench's controller model compares each access with the queued expectation at the falling edge where it raises the acknowledge. It samples pushes, done and the count at falling edges, so each result is read one full half-cycle after the register that produces it.

// File: rtl/rx_drain_pkg.sv
package rx_drain_pkg;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_BURST = 2'd2
    } acc_op_e;

    typedef enum logic [1:0] {
        REG_SIZE  = 2'd0,
        REG_RDPTR = 2'd1,
        REG_CMD   = 2'd2
    } acc_reg_e;

    typedef enum logic [3:0] {
        S_IDLE = 4'd0,
        S_SIZE = 4'd1,
        S_PTR  = 4'd2,
        S_BREQ = 4'd3,
        S_BDAT = 4'd4,
        S_WPTR = 4'd5,
        S_WCMD = 4'd6,
        S_POLL = 4'd7,
        S_DONE = 4'd8
    } drain_st_e;

    localparam logic [15:0] CMD_RECV = 16'h0040;

endpackage

// File: rtl/rx_drain_len.sv
module rx_drain_len #(
    parameter int PTR_W   = 16,
    parameter int FREE_W  = 12,
    parameter int MAX_SEG = 1460,
    parameter int LEN_W   = 11
) (
    input  logic [PTR_W-1:0]  size_i,
    input  logic [FREE_W-1:0] free_i,
    output logic [LEN_W-1:0]  len_o
);
    logic [31:0] lim;

    // smallest of waiting bytes, segment cap and FIFO room
    always_comb begin
        lim = 32'(size_i);
        if (lim > 32'(MAX_SEG)) begin
            lim = 32'(MAX_SEG);
        end
        if (32'(free_i) < lim) begin
            lim = 32'(free_i);
        end
        len_o = lim[LEN_W-1:0];
    end
endmodule

// File: rtl/rx_drain_wrap.sv
module rx_drain_wrap #(
    parameter int OFF_W     = 11,
    parameter int LEN_W     = 11,
    parameter int BUF_BYTES = 2048
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] first_o,
    output logic [LEN_W-1:0] second_o
);
    logic [31:0] room;

    // bytes left before the region end decide the split point
    always_comb begin
        room = 32'(BUF_BYTES) - 32'(off_i);
        if (32'(len_i) <= room) begin
            first_o  = len_i;
            second_o = '0;
        end else begin
            first_o  = room[LEN_W-1:0];
            second_o = len_i - room[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/rx_drain.sv
module rx_drain
    import rx_drain_pkg::*;
#(
    parameter int SOCK_W    = 3,
    parameter int PTR_W     = 16,
    parameter int BUF_BYTES = 2048,
    parameter int MAX_SEG   = 1460,
    parameter int FREE_W    = 12,
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int LEN_W    = $clog2(MAX_SEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SOCK_W-1:0] sock_sel,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              acc_req,
    output logic [1:0]        acc_op,
    output logic [1:0]        acc_reg,
    output logic [SOCK_W-1:0] acc_sock,
    output logic [OFF_W-1:0]  acc_addr,
    output logic [LEN_W-1:0]  acc_len,
    output logic [PTR_W-1:0]  acc_wdata,
    input  logic              acc_ack,
    input  logic [PTR_W-1:0]  acc_rdata,
    input  logic              dat_valid,
    input  logic [7:0]        dat_byte,
    output logic              fifo_push,
    output logic [7:0]        fifo_data,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  done_len
);

    typedef struct packed {
        drain_st_e         st;
        logic [SOCK_W-1:0] sock;
        logic [LEN_W-1:0]  len;
        logic [PTR_W-1:0]  ptr;
        logic              seg;
        logic [LEN_W-1:0]  left;
        logic              push;
        logic [7:0]        data;
    } drain_t;

    drain_t state_d, state_q;

    logic [LEN_W-1:0] pass_len;
    logic [LEN_W-1:0] first_len;
    logic [LEN_W-1:0] second_len;
    logic [LEN_W-1:0] burst_len;
    logic [OFF_W-1:0] buf_off;

    assign buf_off = state_q.ptr[OFF_W-1:0];

    rx_drain_len #(
        .PTR_W  (PTR_W),
        .FREE_W (FREE_W),
        .MAX_SEG(MAX_SEG),
        .LEN_W  (LEN_W)
    ) u_len (
        .size_i(acc_rdata),
        .free_i(fifo_free),
        .len_o (pass_len)
    );

    rx_drain_wrap #(
        .OFF_W    (OFF_W),
        .LEN_W    (LEN_W),
        .BUF_BYTES(BUF_BYTES)
    ) u_wrap (
        .off_i   (buf_off),
        .len_i   (state_q.len),
        .first_o (first_len),
        .second_o(second_len)
    );

    assign burst_len = state_q.seg ? second_len : first_len;

    always_comb begin
        state_d      = state_q;
        state_d.push = 1'b0;
        acc_req      = 1'b0;
        acc_op       = OP_RD;
        acc_reg      = REG_SIZE;
        acc_addr     = '0;
        acc_len      = '0;
        acc_wdata    = '0;
        case (state_q.st)
            S_IDLE: begin
                if (start) begin
                    state_d.sock = sock_sel;
                    state_d.st   = S_SIZE;
                end
            end
            S_SIZE: begin
                acc_req = 1'b1;
                if (acc_ack) begin
                    state_d.len = pass_len;
                    state_d.st  = (pass_len == '0) ? S_DONE : S_PTR;
                end
            end
            S_PTR: begin
                acc_req = 1'b1;
                acc_reg = REG_RDPTR;
                if (acc_ack) begin
                    state_d.ptr = acc_rdata;
                    state_d.seg = 1'b0;
                    state_d.st  = S_BREQ;
                end
            end
            S_BREQ: begin
                acc_req  = 1'b1;
                acc_op   = OP_BURST;
                acc_addr = state_q.seg ? '0 : buf_off;
                acc_len  = burst_len;
                if (acc_ack) begin
                    state_d.left = burst_len;
                    state_d.st   = S_BDAT;
                end
            end
            S_BDAT: begin
                if (dat_valid) begin
                    state_d.push = 1'b1;
                    state_d.data = dat_byte;
                    state_d.left = state_q.left - LEN_W'(1);
                    if (state_q.left == LEN_W'(1)) begin
                        if (!state_q.seg && second_len != '0) begin
                            state_d.seg = 1'b1;
                            state_d.st  = S_BREQ;
                        end else begin
                            state_d.st  = S_WPTR;
                        end
                    end
                end
            end
            S_WPTR: begin
                acc_req   = 1'b1;
                acc_op    = OP_WR;
                acc_reg   = REG_RDPTR;
                acc_wdata = state_q.ptr + PTR_W'(state_q.len);
                if (acc_ack) begin
                    state_d.st = S_WCMD;
                end
            end
            S_WCMD: begin
                acc_req   = 1'b1;
                acc_op    = OP_WR;
                acc_reg   = REG_CMD;
                acc_wdata = CMD_RECV;
                if (acc_ack) begin
                    state_d.st = S_POLL;
                end
            end
            S_POLL: begin
                acc_req = 1'b1;
                acc_reg = REG_CMD;
                if (acc_ack && acc_rdata == '0) begin
                    state_d.st = S_DONE;
                end
            end
            S_DONE: begin
                state_d.st = S_IDLE;
            end
            default: begin
                state_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_sock  = state_q.sock;
    assign fifo_push = state_q.push;
    assign fifo_data = state_q.data;
    assign busy      = (state_q.st != S_IDLE);
    assign done      = (state_q.st == S_DONE);
    assign done_len  = state_q.len;

    // R2: a pending request keeps its fields until accepted
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_ack) |=> (acc_req && $stable(acc_op) && $stable(acc_reg)
                                   && $stable(acc_addr) && $stable(acc_len)));

    // R4: no burst reaches beyond the region end, and none is empty
    a_r4_burst_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_op == OP_BURST) |->
            ((32'(acc_addr) + 32'(acc_len) <= 32'(BUF_BYTES)) && acc_len != '0));

    // R1: an empty socket finishes right after its size read
    a_r1_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_ack && acc_op == OP_RD && acc_reg == REG_SIZE && acc_rdata == '0)
            |=> (done && done_len == '0));

    // R5: reported count never exceeds the segment cap
    a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(done_len) <= 32'(MAX_SEG)));

    // R8: a non-empty pass ends only after the command reads back zero
    a_r8_recv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_len != '0) |->
            $past(acc_req && acc_ack && acc_op == OP_RD && acc_reg == REG_CMD && acc_rdata == '0));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: every FIFO write follows an accepted data beat
    a_r9_push_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(dat_valid));

endmodule

// File: tb/rx_drain_bench.sv
module rx_drain_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  sock_sel = '0;
    logic [11:0] fifo_free = '0;
    logic        acc_req;
    logic [1:0]  acc_op;
    logic [1:0]  acc_reg;
    logic [2:0]  acc_sock;
    logic [10:0] acc_addr;
    logic [10:0] acc_len;
    logic [15:0] acc_wdata;
    logic        acc_ack = 1'b0;
    logic [15:0] acc_rdata = '0;
    logic        dat_valid = 1'b0;
    logic [7:0]  dat_byte = '0;
    logic        fifo_push;
    logic [7:0]  fifo_data;
    logic        busy;
    logic        done;
    logic [10:0] done_len;

    always #5 clk = ~clk;

    rx_drain u_rx_drain (
        .clk(clk), .rst_n(rst_n), .start(start), .sock_sel(sock_sel),
        .fifo_free(fifo_free), .acc_req(acc_req), .acc_op(acc_op),
        .acc_reg(acc_reg), .acc_sock(acc_sock), .acc_addr(acc_addr),
        .acc_len(acc_len), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
        .acc_rdata(acc_rdata), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .fifo_push(fifo_push), .fifo_data(fifo_data), .busy(busy),
        .done(done), .done_len(done_len)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [44:0] exp_txn[$];
    logic [7:0]  exp_byte[$];

    logic [15:0] m_size[8];
    logic [15:0] m_ptr[8];
    int poll_left = 0;
    int lat = 0;
    int s_left = 0;
    int s_off = 0;
    int s_sock = 0;
    int gap = 0;

    function automatic logic [7:0] pat(input int s, input int o);
        return 8'(o * 5 + s * 29 + (o >> 8));
    endfunction

    function automatic logic [44:0] mk(input logic [1:0] op, input logic [1:0] rs,
                                       input logic [2:0] sk, input logic [10:0] ad,
                                       input logic [10:0] ln, input logic [15:0] wd);
        return {op, (op == 2'd2) ? 2'd0 : rs, sk,
                (op == 2'd2) ? ad : 11'd0, (op == 2'd2) ? ln : 11'd0,
                (op == 2'd1) ? wd : 16'd0};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor and controller model share the falling edge
    always @(negedge clk) begin
        logic [44:0] act;
        logic [44:0] ex;
        logic [7:0]  eb;
        if (rst_n && fifo_push) begin
            if (exp_byte.size() == 0) begin
                check(0, "R9", "unexpected push", fifo_data, 0);
            end else begin
                eb = exp_byte.pop_front();
                check(fifo_data == eb, "R9", "fifo byte", fifo_data, eb);
            end
        end
        acc_ack = 1'b0;
        dat_valid = 1'b0;
        if (s_left > 0) begin
            gap++;
            if (gap % 4 != 3) begin
                dat_valid = 1'b1;
                dat_byte = pat(s_sock, s_off);
                s_off = (s_off + 1) % 2048;
                s_left--;
            end
        end
        if (rst_n && acc_req) begin
            lat++;
            if (lat >= 2) begin
                lat = 0;
                act = mk(acc_op, acc_reg, acc_sock, acc_addr, acc_len, acc_wdata);
                if (exp_txn.size() == 0) begin
                    check(0, "R2", "unexpected access", act, 0);
                end else begin
                    ex = exp_txn.pop_front();
                    check(act == ex, "R2", "access", act, ex);
                end
                acc_rdata = '0;
                if (acc_op == 2'd0) begin
                    if (acc_reg == 2'd0) acc_rdata = m_size[acc_sock];
                    else if (acc_reg == 2'd1) acc_rdata = m_ptr[acc_sock];
                    else if (poll_left > 0) begin
                        acc_rdata = 16'h0040;
                        poll_left--;
                    end
                end else if (acc_op == 2'd1) begin
                    if (acc_reg == 2'd1) m_ptr[acc_sock] = acc_wdata;
                    else poll_left = 2;
                end else begin
                    s_left = int'(acc_len);
                    s_off = int'(acc_addr);
                    s_sock = int'(acc_sock);
                    gap = 0;
                end
                acc_ack = 1'b1;
            end
        end else begin
            lat = 0;
        end
    end

    task automatic run_pass(input int s, input int size, input int ptr, input int free,
                            input string tag);
        int len, off, first, second, newp, wait_n;
        bit seen;
        len = size;
        if (len > 1460) len = 1460;
        if (free < len) len = free;
        off = ptr % 2048;
        first = (len <= 2048 - off) ? len : 2048 - off;
        second = len - first;
        newp = (ptr + len) % 65536;
        m_size[s] = 16'(size);
        m_ptr[s] = 16'(ptr);
        fifo_free = 12'(free);
        exp_txn.push_back(mk(2'd0, 2'd0, 3'(s), 0, 0, 0));
        if (len > 0) begin
            exp_txn.push_back(mk(2'd0, 2'd1, 3'(s), 0, 0, 0));
            exp_txn.push_back(mk(2'd2, 2'd0, 3'(s), 11'(off), 11'(first), 0));
            if (second > 0) exp_txn.push_back(mk(2'd2, 2'd0, 3'(s), 0, 11'(second), 0));
            exp_txn.push_back(mk(2'd1, 2'd1, 3'(s), 0, 0, 16'(newp)));
            exp_txn.push_back(mk(2'd1, 2'd2, 3'(s), 0, 0, 16'h0040));
            for (int i = 0; i < 3; i++) exp_txn.push_back(mk(2'd0, 2'd2, 3'(s), 0, 0, 0));
            for (int i = 0; i < len; i++) exp_byte.push_back(pat(s, (off + i) % 2048));
        end
        @(negedge clk);
        start = 1'b1;
        sock_sel = 3'(s);
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        wait_n = 0;
        while (!seen && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
            if (done) seen = 1;
        end
        check(seen, tag, "done pulse seen", seen, 1);
        check(done_len == 11'(len), tag, "done count", done_len, len);
        @(negedge clk);
        #1;
        check(!done, "R9", "done one cycle", done, 0);
        check(exp_txn.size() == 0, "R2", "accesses left", exp_txn.size(), 0);
        check(exp_byte.size() == 0, "R9", "bytes left", exp_byte.size(), 0);
        check(m_ptr[s] == 16'(newp), "R7", "pointer written", m_ptr[s], newp);
        exp_txn.delete();
        exp_byte.delete();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_size[i] = '0;
            m_ptr[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !acc_req && !done && !fifo_push, "R2", "reset idle",
              {busy, acc_req, done, fifo_push}, 0);
        run_pass(0, 0, 16'h0123, 4000, "R1");            // empty socket
        run_pass(2, 100, 16'h0010, 4000, "R3");          // plain pass
        run_pass(5, 300, 16'h07F0, 4000, "R4");          // wraps: 16 then 284
        run_pass(1, 3000, 16'h1234, 4095, "R5");         // capped at 1460
        run_pass(3, 500, 16'h0200, 37, "R5");            // FIFO limits to 37
        run_pass(4, 50, 16'h0300, 0, "R6");              // FIFO full
        run_pass(7, 40, 16'hFFF0, 4000, "R7");           // pointer rolls over 16 bits
        run_pass(6, 256, 16'h0700, 4000, "R4");          // ends exactly at region end
        run_pass(2, 1460, 16'h0400, 1460, "R8");         // long pass with poll loop
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule